// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fetcher

The block reads one four-word cache line from a main memory built as four word-wide banks, where the two lowest bits of a word address pick the bank. A requester offers a word address with a mode bit. The fetcher then spends one cycle on the address phase, starts the banks, and returns the four words over a single one-word bus, lowest index first. Each word carries a valid strobe and its index, and a completion pulse marks the last one. The banks are modelled inside the block as fixed-latency behavioural storage whose content is a function of the address, so the fetcher can be exercised on its own.

In the default overlapped mode all four banks start in the same cycle, so their access times overlap and the bus drains the four results back to back. The whole line takes 1 + LAT + 4 cycles (10 with the default latency of 5). In sequential mode the banks are used one after another, each needing its full access time plus one bus cycle. This gives 1 + 4 × (LAT + 1) cycles (25 by default), which serves as the baseline for comparison. The controller is a four-state machine. IDLE goes to ADDR when a request is offered. ADDR always goes to WAIT. WAIT goes to XFER once the latency count reaches zero. From XFER the machine returns to IDLE after word 3, moves back to WAIT in sequential mode, and otherwise stays in XFER for the next word.

Top module: `ibf_fetch`

## Requirements
- R1: While reset is low and in the first cycle after it is released, req_ready is 1 and word_valid and blk_done are 0. A reset during a fetch ends it with no further words.
- R2: A request is taken at a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle through the cycle that carries blk_done, and it is 1 again in the cycle after that.
- R3: The line base is req_addr with its two lowest bits cleared. Word i is read from address base + i, so the two lowest bits of req_addr have no effect on which words return.
- R4: The word stored at word address A reads as A zero-extended, placed in both the low half and the high half of the data word ({A, A} with 16-bit addresses and 32-bit data).
- R5: With req_seq = 0, count cycle 1 as the cycle that starts at the accepting edge. Word i is then on the outputs in cycle LAT + 2 + i (cycles 7 to 10 by default), and the line completes in cycle 1 + LAT + 4.
- R6: With req_seq = 1 taken at acceptance, word i is on the outputs in cycle (i + 1)(LAT + 1) + 1 (cycles 7, 13, 19 and 25 by default), and the line completes in cycle 1 + 4(LAT + 1).
- R7: word_valid is 1 only in the four word cycles of a fetch, and word_idx then reads 0, 1, 2 and 3 in that order.
- R8: blk_done is 1 for exactly one cycle per line, in the cycle of word 3, together with word_valid.
- R9: Changes to req_valid, req_addr or req_seq while a fetch is in progress do not alter its words, its timing or its mode, and they do not start another fetch once it ends.
- R10: In every word cycle, the bank that word_idx selects has finished its access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A line request is offered |
| req_addr | input | ADDR_W | Word address inside the wanted line |
| req_seq | input | 1 | 1 selects sequential bank use, 0 selects overlapped |
| req_ready | output | 1 | Fetcher is idle and takes a request |
| word_valid | output | 1 | word_data and word_idx hold a returned word |
| word_idx | output | 2 | Position of the returned word within the line |
| word_data | output | DATA_W | Returned word |
| blk_done | output | 1 | Last word of the line is on the bus |

## Verification
A latency counter that is wrong by one cycle moves every word of the line by the same number of cycles, and so does a bank start issued in the wrong state. The cycle-exact word schedule in both modes catches either fault on the very first fetch. If the word index does not advance correctly, or the wrong bank is started, the data no longer matches {A, A} for the expected address in that word's own cycle. If the machine fails to leave XFER or WAIT, req_ready stays low past the completion cycle, which is exposed one cycle after blk_done. If the mode is sampled at the wrong time, the spacing between words changes from one cycle to LAT + 1 cycles, which shows up on the second word.

// File: rtl/ibf_pkg.sv
package ibf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_XFER
    } ibf_state_e;

    // Cycles from the accepting edge until the last word, both modes.
    function automatic int unsigned line_cycles(input int unsigned lat, input logic seq);
        int unsigned n;
        if (seq) n = 1 + 4 * (lat + 1);
        else     n = 1 + lat + 4;
        return n;
    endfunction

endpackage

// File: rtl/ibf_bank.sv
module ibf_bank #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LAT    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              vld
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam int HALF  = DATA_W / 2;

    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic [DATA_W-1:0] data_q;
    logic              vld_q;
    logic [DATA_W-1:0] a_ext;
    logic [DATA_W-1:0] pattern;

    // Modelled content: the address, copied into both halves of the word.
    always_comb begin
        a_ext   = DATA_W'(addr);
        pattern = (a_ext << HALF) | a_ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            data_q <= '0;
            vld_q  <= 1'b0;
        end else if (start) begin
            cnt_q  <= CNT_W'(LAT - 1);
            busy_q <= 1'b1;
            data_q <= pattern;
            vld_q  <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                vld_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign data = data_q;
    assign vld  = vld_q;

endmodule

// File: rtl/ibf_ctrl.sv
module ibf_ctrl
    import ibf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LAT    = 5,
    parameter int NBANK  = 4,
    localparam int IDX_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    output logic              req_ready,
    output logic [NBANK-1:0]  bank_start,
    output logic [ADDR_W-1:0] base_addr,
    output logic              xfer,
    output logic [IDX_W-1:0]  idx,
    output logic              done
);
    localparam int WCNT_W            = $clog2(LAT + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBANK - 1);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(NBANK - 1);

    ibf_state_e        state_q, state_d;
    logic [WCNT_W-1:0] wcnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic              seq_q;
    logic [ADDR_W-1:0] base_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_WAIT;
            ST_WAIT: if (wcnt_q == '0) state_d = ST_XFER;
            ST_XFER: begin
                if (idx_q == LAST) state_d = ST_IDLE;
                else if (seq_q)    state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath registers: line base, mode, latency count, word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            idx_q  <= '0;
            seq_q  <= 1'b0;
            base_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        base_q <= req_addr & ~LOW_MASK;
                        seq_q  <= req_seq;
                        idx_q  <= '0;
                    end
                end
                ST_ADDR: wcnt_q <= WCNT_W'(LAT - 1);
                ST_WAIT: begin
                    if (wcnt_q != '0) wcnt_q <= wcnt_q - 1'b1;
                end
                ST_XFER: begin
                    if (idx_q != LAST) begin
                        idx_q <= idx_q + 1'b1;
                        if (seq_q) wcnt_q <= WCNT_W'(LAT - 1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        xfer       = (state_q == ST_XFER);
        done       = xfer && (idx_q == LAST);
        idx        = idx_q;
        base_addr  = base_q;
        bank_start = '0;
        unique case (state_q)
            ST_ADDR: bank_start = seq_q ? NBANK'(1) : {NBANK{1'b1}};
            ST_XFER: begin
                if (seq_q && idx_q != LAST)
                    bank_start = NBANK'(1) << (32'(idx_q) + 1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ibf_fetch.sv
module ibf_fetch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LAT    = 5,
    parameter int NBANK  = 4,
    localparam int IDX_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    output logic              req_ready,
    output logic              word_valid,
    output logic [IDX_W-1:0]  word_idx,
    output logic [DATA_W-1:0] word_data,
    output logic              blk_done
);
    logic [NBANK-1:0]  bank_start;
    logic [NBANK-1:0]  bank_vld;
    logic [DATA_W-1:0] bank_data [NBANK];
    logic [ADDR_W-1:0] base_addr;
    logic              xfer;
    logic [IDX_W-1:0]  idx;
    logic              done;

    ibf_ctrl #(
        .ADDR_W (ADDR_W),
        .LAT    (LAT),
        .NBANK  (NBANK)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_seq    (req_seq),
        .req_ready  (req_ready),
        .bank_start (bank_start),
        .base_addr  (base_addr),
        .xfer       (xfer),
        .idx        (idx),
        .done       (done)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ibf_bank #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .LAT    (LAT)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .start (bank_start[b]),
            .addr  (base_addr | ADDR_W'(b)),
            .data  (bank_data[b]),
            .vld   (bank_vld[b])
        );
    end

    always_comb begin
        word_valid = xfer;
        word_idx   = idx;
        word_data  = xfer ? bank_data[idx] : '0;
        blk_done   = done;
    end

endmodule

// File: rtl/ibf_fetch_chk.sv
module ibf_fetch_chk #(
    parameter int LAT    = 5,
    parameter int NBANK  = 4,
    localparam int IDX_W = $clog2(NBANK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_seq,
    input logic             word_valid,
    input logic [IDX_W-1:0] word_idx,
    input logic             blk_done,
    input logic [NBANK-1:0] bank_vld
);
    localparam int unsigned N_OVL = ibf_pkg::line_cycles(LAT, 1'b0);
    localparam int unsigned N_SEQ = ibf_pkg::line_cycles(LAT, 1'b1);

    logic [15:0] cyc_q;
    logic        mode_q;
    logic        take;

    assign take = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            mode_q <= 1'b0;
        end else if (take) begin
            cyc_q  <= 16'd1;
            mode_q <= req_seq;
        end else if (!req_ready) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R2
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !req_ready);

    // R2
    no_word_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> !req_ready);

    // R5
    ovl_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !mode_q) |-> (32'(cyc_q) == N_OVL));

    // R6
    seq_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && mode_q) |-> (32'(cyc_q) == N_SEQ));

    // R6
    seq_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && mode_q && !blk_done) |=> !word_valid);

    // R7
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && $past(word_valid)) |-> (word_idx == $past(word_idx) + 1'b1));

    // R8
    done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (word_valid && word_idx == IDX_W'(NBANK - 1)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);

    // R10
    bank_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> bank_vld[word_idx]);

endmodule

bind ibf_fetch ibf_fetch_chk #(
    .LAT   (LAT),
    .NBANK (NBANK)
) u_fetch_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_seq    (req_seq),
    .word_valid (word_valid),
    .word_idx   (word_idx),
    .blk_done   (blk_done),
    .bank_vld   (bank_vld)
);

// File: tb/test_ibf_fetch.sv
module test_ibf_fetch;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_seq = 1'b0;
    logic        req_ready;
    logic        word_valid;
    logic [1:0]  word_idx;
    logic [31:0] word_data;
    logic        blk_done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ibf_fetch #(.LAT(LAT)) i_ibf_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_seq    (req_seq),
        .req_ready  (req_ready),
        .word_valid (word_valid),
        .word_idx   (word_idx),
        .word_data  (word_data),
        .blk_done   (blk_done)
    );

    // {seq, address}
    localparam logic [16:0] VEC [8] = '{
        17'h0_0000, 17'h0_1234, 17'h1_0040, 17'h0_FFFF,
        17'h1_ABCF, 17'h0_0007, 17'h1_FFFE, 17'h0_8001
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Cycle in which word i shows, counting the cycle after the accepting edge as 1.
    function automatic int word_cycle(input bit seq, input int i);
        return seq ? (i + 1) * (LAT + 1) + 1 : LAT + 2 + i;
    endfunction

    task automatic run_fetch(input bit seq, input logic [15:0] addr, input bit poke);
        int total;
        logic [15:0] base;
        total = seq ? 1 + 4 * (LAT + 1) : 1 + LAT + 4;
        base  = {addr[15:2], 2'b00};
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_seq   = seq;
        @(negedge clk);
        req_valid = 1'b0;
        req_seq   = ~seq;       // R9: mode change after acceptance
        req_addr  = ~addr;      // R9: address change after acceptance
        for (int c = 1; c <= total; c++) begin
            int wi;
            wi = -1;
            for (int i = 0; i < 4; i++) if (c == word_cycle(seq, i)) wi = i;
            chk(req_ready == 1'b0, "R2", "ready during fetch", 32'(req_ready), 32'd0);
            if (wi >= 0) begin
                chk(word_valid == 1'b1, seq ? "R6" : "R5", "word valid", 32'(word_valid), 32'd1);
                chk(word_idx == 2'(wi), "R7", "word index", 32'(word_idx), 32'(wi));
                chk(word_data == {base + 16'(wi), base + 16'(wi)}, "R4 R3", "word data",
                    word_data, {base + 16'(wi), base + 16'(wi)});
                chk(blk_done == (wi == 3), "R8", "done pulse", 32'(blk_done), 32'(wi == 3));
            end else begin
                chk(word_valid == 1'b0 && blk_done == 1'b0, "R7", "idle bus",
                    32'({word_valid, blk_done}), 32'd0);
            end
            if (poke) req_valid = (c >= 3 && c < 5);   // R9: request while busy
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(req_ready == 1'b1 && word_valid == 1'b0, "R2", "ready after line",
            32'({req_ready, word_valid}), 32'h2);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                chk(word_valid == 1'b0 && req_ready == 1'b1, "R9", "no extra fetch",
                    32'({req_ready, word_valid}), 32'h2);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && word_valid == 1'b0 && blk_done == 1'b0, "R1", "in reset",
            32'({req_ready, word_valid, blk_done}), 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && word_valid == 1'b0 && blk_done == 1'b0, "R1", "after reset",
            32'({req_ready, word_valid, blk_done}), 32'h4);

        // Table walk: back-to-back lines in both modes
        for (int v = 0; v < 8; v++) run_fetch(VEC[v][16], VEC[v][15:0], 1'b0);

        // R9: requests offered while busy, both modes
        run_fetch(1'b0, 16'h2222, 1'b1);
        run_fetch(1'b1, 16'h3331, 1'b1);

        // R3: unaligned address gives the same line as the aligned one
        run_fetch(1'b0, 16'h5553, 1'b0);

        // R1: reset in the middle of a line
        req_valid = 1'b1;
        req_addr  = 16'h0100;
        req_seq   = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            chk(word_valid == 1'b0 && blk_done == 1'b0 && req_ready == 1'b1, "R1",
                "reset mid-line", 32'({req_ready, word_valid, blk_done}), 32'h4);
            @(negedge clk);
        end
        run_fetch(1'b1, 16'h0104, 1'b0);

        summary();
        $finish;
    end

endmodule